// File: doc/BRIEF.md
# Presettable Cascadable Binary Counter

This block is a synchronous up-counter of parameterised width (four bits by default). It has an active-low clear that takes effect at once, without waiting for the clock. It has an active-low parallel load that is sampled on the rising clock edge. Two count enables gate the increment.

The first enable, `en_local`, only gates counting. The second, `en_chain`, gates counting and also qualifies the carry output. Because of this, several instances can be chained into one wider synchronous counter with no extra logic. Each stage's `carry_out` drives the next stage's `en_chain`. Clock, clear, load and `en_local` are shared by all stages.

Load takes precedence over both enables. Clear takes precedence over everything.

Top module: `casc_counter`

## Requirements
- R1: The stored count changes only on a rising edge of `clk`, or when clear is applied. All bits update together. Changes on `load_n`, `din`, `en_local` or `en_chain` between edges leave `q` unchanged.
- R2: While `clear_n` is low, `q` is 0 immediately, whatever the clock, load and enable levels are.
- R3: With `clear_n` high and `load_n` low, the next rising edge copies `din` into `q`, whatever the enable levels are. Bit i of `din` goes to bit i of `q`, with bit 0 the least significant.
- R4: With `clear_n` and `load_n` high and both `en_local` and `en_chain` high, each rising edge adds one to `q`.
- R5: With `clear_n` and `load_n` high and either enable low, `q` holds its value across the edge.
- R6: `carry_out` is high exactly when `en_chain` is high and every bit of `q` is 1. It is combinational, so it follows `en_chain` without a clock edge.
- R7: From the all-ones value, an enabled increment wraps `q` to 0. For example, a preset of 12 gives 13, 14, 15, 0, 1, 2 in the default width.
- R8: When stages are chained with each `carry_out` driving the next stage's `en_chain`, the combined value steps through every one of its 2^(WIDTH*stages) states in order and then wraps.
- R9: A load shared by all chained stages presets every stage on the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clear_n | input | 1 | Active-low asynchronous clear |
| load_n | input | 1 | Active-low synchronous parallel load |
| en_local | input | 1 | Count enable that does not affect the carry |
| en_chain | input | 1 | Count enable that also qualifies `carry_out` |
| din | input | WIDTH | Parallel preset value |
| q | output | WIDTH | Current count |
| carry_out | output | 1 | High when `en_chain` is high and `q` is all ones |

## Verification
The bench targets the edges between modes.

- It loads with both enables low. A design that gated load behind the enables would keep its old value.
- It wraps from 15 to 0. A design that saturated, or carried into a lost bit, would stop at 15.
- It drops `en_chain` while the count sits at 15. The carry must fall with no clock edge, so a registered carry would show up one cycle late.
- It pulses clear between edges, and it changes load and data between edges. These expose a clear that only acts on the clock, and a load that is acted on before the edge.
- A three-stage chain is counted through all 4096 states. A carry that ignored `en_chain` would make the upper stages advance early.

// File: rtl/casc_counter.sv
module casc_counter #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clear_n,
  input  logic             load_n,
  input  logic             en_local,
  input  logic             en_chain,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q,
  output logic             carry_out
);

  logic [WIDTH-1:0] cnt;
  logic             step;
  logic             at_top;

  assign step   = en_local & en_chain;
  assign at_top = &cnt;

  always_ff @(posedge clk or negedge clear_n) begin
    if (!clear_n)
      cnt <= '0;
    else if (!load_n)
      cnt <= din;
    else if (step)
      cnt <= cnt + 1'b1;
  end

  assign q         = cnt;
  assign carry_out = en_chain & at_top;

endmodule

// File: rtl/casc_counter_chk.sv
module casc_counter_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             clear_n,
  input logic             load_n,
  input logic             en_local,
  input logic             en_chain,
  input logic [WIDTH-1:0] din,
  input logic [WIDTH-1:0] q,
  input logic             carry_out
);

  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  // R2
  clear_zero_chk: assert property (@(posedge clk) !clear_n |-> q == '0);

  // R3
  load_copy_chk: assert property (@(posedge clk) disable iff (!clear_n)
    !load_n |=> q == $past(din));

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!clear_n)
    (load_n && en_local && en_chain) |=> q == $past(q) + ONE);

  // R5
  hold_value_chk: assert property (@(posedge clk) disable iff (!clear_n)
    (load_n && !(en_local && en_chain)) |=> $stable(q));

  // R7
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!clear_n)
    (carry_out && en_local && load_n) |=> q == '0);

endmodule

bind casc_counter casc_counter_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/test_casc_counter.sv
module test_casc_counter;
  localparam int PERIOD = 10;
  localparam int W      = 4;
  localparam int STAGES = 3;
  localparam int CW     = W * STAGES;

  logic clk = 0;
  logic clear_n, load_n, en_local, en_chain;
  logic [W-1:0] din, q;
  logic carry_out;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  casc_counter #(.WIDTH(W)) i_casc_counter (
    .clk(clk), .clear_n(clear_n), .load_n(load_n), .en_local(en_local),
    .en_chain(en_chain), .din(din), .q(q), .carry_out(carry_out)
  );

  logic          c_load_n, c_en_local, c_en_top;
  logic [CW-1:0] c_din, c_q;
  logic [STAGES-1:0] c_carry, c_enc;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    if (k == 0) begin : g_first
      assign c_enc[k] = c_en_top;
    end else begin : g_next
      assign c_enc[k] = c_carry[k-1];
    end
    casc_counter #(.WIDTH(W)) u_stage (
      .clk(clk), .clear_n(clear_n), .load_n(c_load_n), .en_local(c_en_local),
      .en_chain(c_enc[k]), .din(c_din[k*W +: W]), .q(c_q[k*W +: W]),
      .carry_out(c_carry[k])
    );
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    chk("R2 reset count", q, 0);
    chk("R6 reset carry", carry_out, 0);
  endtask

  task automatic t_load_and_wrap;
    load_n = 0; din = 4'd12; en_local = 0; en_chain = 0;
    tick;
    chk("R3 load with enables low", q, 12);
    load_n = 1; en_local = 1; en_chain = 1;
    tick; chk("R4 count 13", q, 13);
    tick; chk("R4 count 14", q, 14);
    tick; chk("R4 count 15", q, 15);
    chk("R6 carry at 15", carry_out, 1);
    en_chain = 0; #1;
    chk("R6 carry follows en_chain low", carry_out, 0);
    en_chain = 1; #1;
    chk("R6 carry follows en_chain high", carry_out, 1);
    tick; chk("R7 wrap to 0", q, 0);
    chk("R6 carry low at 0", carry_out, 0);
    tick; chk("R7 count 1", q, 1);
    tick; chk("R7 count 2", q, 2);
  endtask

  task automatic t_hold;
    en_local = 0; en_chain = 1;
    tick; chk("R5 hold en_local low", q, 2);
    en_local = 1; en_chain = 0;
    tick; chk("R5 hold en_chain low", q, 2);
    en_local = 0; en_chain = 0;
    tick; chk("R5 hold both low", q, 2);
  endtask

  task automatic t_load_priority;
    en_local = 1; en_chain = 1; load_n = 0; din = 4'b1001;
    tick; chk("R3 load beats count, bit order", q, 4'b1001);
    din = 4'b0110;
    tick; chk("R3 second load", q, 4'b0110);
    load_n = 1;
  endtask

  task automatic t_between_edges;
    en_local = 0; en_chain = 0;
    #2;
    load_n = 0; din = 4'd3; en_local = 1; en_chain = 1; #2;
    chk("R1 no change before edge", q, 4'b0110);
    load_n = 1; en_local = 0; en_chain = 0;
    tick; chk("R1 last levels rule at edge", q, 4'b0110);
  endtask

  task automatic t_async_clear;
    en_local = 1; en_chain = 1; load_n = 0; din = 4'd15;
    #2; clear_n = 0; #1;
    chk("R2 clear between edges", q, 0);
    chk("R6 carry after clear", carry_out, 0);
    tick;
    chk("R2 clear beats load", q, 0);
    #1; clear_n = 1; load_n = 1;
    tick; chk("R4 count after clear", q, 1);
  endtask

  task automatic t_chain;
    logic [CW-1:0] exp;
    c_load_n = 0; c_din = '0; c_en_local = 1; c_en_top = 1;
    tick; chk("R9 chain preset 0", c_q, 0);
    c_load_n = 1;
    exp = '0;
    for (int i = 0; i < (1 << CW); i++) begin
      if (exp == {CW{1'b1}}) chk("R8 chain top carry", c_carry[STAGES-1], 1);
      tick;
      exp = exp + 1'b1;
      chk("R8 chain sequence", c_q, exp);
    end
    c_en_top = 0;
    tick; chk("R8 chain hold", c_q, 0);
    c_load_n = 0; c_din = 12'hABC; c_en_local = 0;
    tick; chk("R9 global preset", c_q, 12'hABC);
    c_load_n = 1; c_en_local = 1; c_en_top = 1;
    tick; chk("R8 count after preset", c_q, 12'hABD);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    clear_n = 0; load_n = 1; en_local = 0; en_chain = 0; din = '0;
    c_load_n = 1; c_en_local = 0; c_en_top = 0; c_din = '0;
    #(PERIOD * 2 + 3);
    t_reset;
    clear_n = 1;
    tick;
    t_load_and_wrap;
    t_hold;
    t_load_priority;
    t_between_edges;
    t_async_clear;
    t_chain;
    finish_run();
  end
endmodule